// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge and Completion Interface

This block is the guest-facing side of a virtual interrupt controller. It keeps one bank of four list registers per virtual CPU. A hypervisor fills the list registers through the same register port, and each entry describes one virtual interrupt: its identifier, the CPU that raised it, a priority, a lifecycle state and a flag for hardware-linked interrupts. Guest software reads an acknowledge register to take the most urgent pending interrupt. It writes a completion register to retire an interrupt it has finished handling.

Every access on the 32-bit port carries a CPU index, and that index selects the bank the access works on. Read data returns one cycle after the request. The block drives one virtual IRQ line per CPU. It also gives two one-cycle error pulses: one for an attempt to acknowledge a hardware-linked entry, and one for an access to an offset that nothing decodes.

Top module: `virq_ack_if`

## Requirements
- R1: The control register at offset 0x00 holds the bank enable in bit 0. It resets to 0 and reads back with all other bits zero.
- R2: A read of the acknowledge register (0x04) returns 1023 and changes no state when the bank is disabled or when no entry has state 1 (pending).
- R3: Otherwise the acknowledge read returns the chosen entry's virtual ID in bits [9:0] and its source CPU in bits [12:10], with all other bits zero.
- R4: The acknowledged entry's state field (bits [29:28]) becomes 2 (active). All its other bits stay unchanged.
- R5: The chosen entry is the pending entry with the smallest priority field (bits [27:23]). On equal priority, the lowest entry index wins.
- R6: A write to the completion register (0x08) takes the virtual ID from bits [9:0] and the source CPU from bits [12:10]. It sets to 0 (invalid) the state of the lowest-index entry whose state is non-zero and whose ID and source both match. All other bits of that entry stay unchanged.
- R7: A completion write that matches no entry changes no entry.
- R8: If the chosen entry has its hardware bit (bit 31) set in an enabled bank, the acknowledge read returns 1023, pulses hw_err for one cycle together with the response, and leaves the entry unchanged.
- R9: virq[c] is high exactly when bank c is enabled and at least one of its entries has state 1. It follows register state, so it changes in the cycle after the access that causes the change.
- R10: Entry i is at offset 0x40 + 4*i. It is read and written as a full 32-bit word and resets to 0.
- R11: A read at an undecoded offset, a write to 0x04, or a read of 0x08 returns 0 for a read, has no effect for a write, and pulses dec_err for one cycle.
- R12: An access changes only the bank named by req_cpu.
- R13: Every read raises rsp_valid with its data in the following cycle. A write never raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Bank (virtual CPU) index |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| hw_err | output | 1 | Hardware-linked entry acknowledge attempt |
| dec_err | output | 1 | Undecoded access |
| virq | output | NCPU | Virtual IRQ line per CPU |

## Verification
The virq line and the acknowledge response can change in the same cycle. When the guest acknowledges the last pending entry of an enabled bank, the response word appears in the same cycle that virq for that bank drops. When a completion write removes the last pending entry, virq drops in the cycle after that write. The bench provokes both cases, directed and in a long random run over four banks. A behavioural model predicts virq, the response word and both error pulses on every clock edge, and each prediction is compared in the cycle the design's registers settle.

// File: rtl/vgi_pkg.sv
// Package: shared types and register offsets of the virtual interrupt
// acknowledge interface. Assumes a 32-bit register word.
package vgi_pkg;

    // Lifecycle state of a list entry.
    typedef enum logic [1:0] {
        ST_INV  = 2'd0,
        ST_PEND = 2'd1,
        ST_ACT  = 2'd2,
        ST_PA   = 2'd3
    } lr_state_e;

    // One list entry, most significant field first.
    typedef struct packed {
        logic       hw;      // [31] hardware-linked
        logic       rsv_a;   // [30]
        lr_state_e  st;      // [29:28]
        logic [4:0] prio;    // [27:23]
        logic [2:0] rsv_b;   // [22:20]
        logic       notify;  // [19] EOI notify
        logic [5:0] rsv_c;   // [18:13]
        logic [2:0] src;     // [12:10] source CPU
        logic [9:0] vid;     // [9:0]  virtual ID
    } lr_t;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_ACK  = 'h04;
    localparam int OFF_EOI  = 'h08;
    localparam int OFF_LR0  = 'h40;
    localparam logic [31:0] NO_IRQ = 32'd1023;

endpackage

// File: rtl/vgi_pick.sv
// Module: picks the most urgent pending entry of one bank.
// Assumes: lower priority value is more urgent; ties resolved by lowest index.
module vgi_pick
    import vgi_pkg::*;
#(
    parameter int NLR  = 4,
    localparam int LR_W = $clog2(NLR)
) (
    input  lr_t [NLR-1:0]  lr,
    output logic           found,
    output logic [LR_W-1:0] idx
);
    logic [4:0] best;

    // Linear scan: strict less-than keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < NLR; i++) begin
            if (lr[i].st == ST_PEND && (!found || lr[i].prio < best)) begin
                found = 1'b1;
                idx   = LR_W'(i);
                best  = lr[i].prio;
            end
        end
    end
endmodule

// File: rtl/vgi_lr_bank.sv
// Module: one virtual CPU's enable bit and list entries, with the
// acknowledge and completion state changes and the virq output.
// Assumes: at most one of ctrl_we, lr_we, ack_re, eoi_we is high per cycle.
module vgi_lr_bank
    import vgi_pkg::*;
#(
    parameter int NLR  = 4,
    localparam int LR_W = $clog2(NLR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic            lr_we,
    input  logic            ack_re,
    input  logic            eoi_we,
    input  logic [LR_W-1:0] lr_idx,
    input  logic [31:0]     wdata,
    output logic            en_q,
    output lr_t [NLR-1:0]   lr_q,
    output logic [31:0]     ack_word,
    output logic            ack_hw,
    output logic            virq
);
    logic            found;
    logic [LR_W-1:0] pick_idx;
    logic            eoi_hit;
    logic [LR_W-1:0] eoi_idx;
    logic            ack_take;

    vgi_pick #(.NLR(NLR)) u_pick (
        .lr    (lr_q),
        .found (found),
        .idx   (pick_idx)
    );

    // Completion search: lowest-index live entry with matching ID and source.
    always_comb begin
        eoi_hit = 1'b0;
        eoi_idx = '0;
        for (int i = NLR - 1; i >= 0; i--) begin
            if (lr_q[i].st != ST_INV && lr_q[i].vid == wdata[9:0]
                && lr_q[i].src == wdata[12:10]) begin
                eoi_hit = 1'b1;
                eoi_idx = LR_W'(i);
            end
        end
    end

    // Acknowledge result word and error condition for this bank.
    always_comb begin
        ack_take = ack_re && en_q && found && !lr_q[pick_idx].hw;
        ack_hw   = en_q && found && lr_q[pick_idx].hw;
        if (en_q && found && !lr_q[pick_idx].hw)
            ack_word = {19'd0, lr_q[pick_idx].src, lr_q[pick_idx].vid};
        else
            ack_word = NO_IRQ;
    end

    // State registers: enable, entry loads, acknowledge and completion updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            lr_q <= '0;
        end else begin
            if (ctrl_we)
                en_q <= wdata[0];
            if (lr_we)
                lr_q[lr_idx] <= lr_t'(wdata);
            if (ack_take)
                lr_q[pick_idx].st <= ST_ACT;
            if (eoi_we && eoi_hit)
                lr_q[eoi_idx].st <= ST_INV;
        end
    end

    // Virtual IRQ: enabled bank with anything pending.
    always_comb begin
        virq = 1'b0;
        for (int i = 0; i < NLR; i++)
            if (lr_q[i].st == ST_PEND)
                virq = en_q;
    end

    // The acknowledged entry turns active on the next cycle.
    p_ack_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> lr_q[$past(pick_idx)].st == ST_ACT);

    // A matched completion invalidates that entry.
    p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && eoi_hit) |=> lr_q[$past(eoi_idx)].st == ST_INV);

    // An unmatched completion leaves the entries alone.
    p_eoi_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && !eoi_hit) |=> $stable(lr_q));

    // A hardware-linked pick is not consumed.
    p_hw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_re && ack_hw) |=> $stable(lr_q));
endmodule

// File: rtl/virq_ack_if.sv
// Module: top of the virtual interrupt acknowledge interface. Decodes the
// register port, steers each access to the bank named by req_cpu, and
// registers the read response and error pulses.
// Assumes: NCPU is a power of two; OFF_LR0 is aligned to NLR*4.
module virq_ack_if
    import vgi_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NLR    = 4,
    parameter int ADDR_W = 8,
    localparam int CPU_W = $clog2(NCPU),
    localparam int LR_W  = $clog2(NLR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              hw_err,
    output logic              dec_err,
    output logic [NCPU-1:0]   virq
);
    localparam int LR_SHIFT = LR_W + 2;

    logic            is_ctrl, is_ack, is_eoi, is_lr;
    logic            acc_ok;
    logic [LR_W-1:0] lr_idx;
    logic [31:0]     rd_d;
    logic            hw_d;

    logic            b_en   [NCPU];
    lr_t [NLR-1:0]   b_lr   [NCPU];
    logic [31:0]     b_ack  [NCPU];
    logic            b_hw   [NCPU];

    // Offset decode and direction legality.
    always_comb begin
        is_ctrl = req_addr == ADDR_W'(OFF_CTRL);
        is_ack  = req_addr == ADDR_W'(OFF_ACK);
        is_eoi  = req_addr == ADDR_W'(OFF_EOI);
        is_lr   = req_addr[ADDR_W-1:LR_SHIFT] == (ADDR_W-LR_SHIFT)'(OFF_LR0 >> LR_SHIFT)
                  && req_addr[1:0] == 2'b00;
        lr_idx  = req_addr[LR_SHIFT-1:2];
        acc_ok  = is_ctrl || is_lr || (req_write ? is_eoi : is_ack);
    end

    // One bank per virtual CPU.
    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        logic sel;
        assign sel = req_valid && acc_ok && req_cpu == CPU_W'(c);
        vgi_lr_bank #(.NLR(NLR)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (sel && req_write && is_ctrl),
            .lr_we    (sel && req_write && is_lr),
            .ack_re   (sel && !req_write && is_ack),
            .eoi_we   (sel && req_write && is_eoi),
            .lr_idx   (lr_idx),
            .wdata    (req_wdata),
            .en_q     (b_en[c]),
            .lr_q     (b_lr[c]),
            .ack_word (b_ack[c]),
            .ack_hw   (b_hw[c]),
            .virq     (virq[c])
        );
    end

    // Read data select from the addressed bank.
    always_comb begin
        rd_d = '0;
        hw_d = 1'b0;
        if (acc_ok && !req_write) begin
            if (is_ctrl)
                rd_d = {31'd0, b_en[req_cpu]};
            else if (is_ack) begin
                rd_d = b_ack[req_cpu];
                hw_d = b_hw[req_cpu];
            end else
                rd_d = b_lr[req_cpu][lr_idx];
        end
    end

    // Response and error pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            hw_err    <= 1'b0;
            dec_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= rd_d;
            hw_err    <= req_valid && !req_write && hw_d;
            dec_err   <= req_valid && !acc_ok;
        end
    end

    // Reads answer next cycle; writes never answer.
    p_rsp_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_rsp_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // Disabled bank acknowledges with the no-interrupt code.
    p_ack_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && is_ack && !b_en[req_cpu]) |=> rsp_rdata == NO_IRQ);

    // Hardware-linked error carries the no-interrupt code.
    p_hw_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |-> (rsp_valid && rsp_rdata == NO_IRQ));

    // Undecoded reads return zero.
    p_dec_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_err && rsp_valid) |-> rsp_rdata == 32'd0);
endmodule

// File: tb/sim_virq_ack_if.sv
module sim_virq_ack_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, hw_err, dec_err;
    logic [31:0] rsp_rdata;
    logic [3:0]  virq;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    string cur_tag = "R1";

    // Reference model state.
    logic [31:0] m_lr [4][4];
    logic        m_en [4];
    logic        e_rv, e_hw, e_de;
    logic [31:0] e_rd;

    virq_ack_if u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hw_err(hw_err),
        .dec_err(dec_err), .virq(virq)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        cyc++;
        e_rv = 1'b0; e_hw = 1'b0; e_de = 1'b0;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 1'b0;
                for (int i = 0; i < 4; i++) m_lr[c][i] = '0;
            end
            e_rd = '0;
        end else if (req_valid) begin
            automatic int c = req_cpu;
            automatic int a = req_addr;
            if (!req_write) begin
                e_rv = 1'b1;
                e_rd = '0;
                if (a == 0) e_rd = {31'd0, m_en[c]};
                else if (a == 4) begin
                    automatic int best = -1;
                    for (int i = 0; i < 4; i++)
                        if (m_lr[c][i][29:28] == 2'd1 &&
                            (best < 0 || m_lr[c][i][27:23] < m_lr[c][best][27:23]))
                            best = i;
                    if (!m_en[c] || best < 0) e_rd = 32'd1023;
                    else if (m_lr[c][best][31]) begin e_rd = 32'd1023; e_hw = 1'b1; end
                    else begin
                        e_rd = {19'd0, m_lr[c][best][12:0]};
                        m_lr[c][best][29:28] = 2'd2;
                    end
                end else if (a >= 'h40 && a <= 'h4c && a % 4 == 0) e_rd = m_lr[c][(a - 'h40) / 4];
                else e_de = 1'b1;
            end else begin
                if (a == 0) m_en[c] = req_wdata[0];
                else if (a == 8) begin
                    automatic bit done = 1'b0;
                    for (int i = 0; i < 4; i++)
                        if (!done && m_lr[c][i][29:28] != 2'd0 && m_lr[c][i][12:0] == req_wdata[12:0]) begin
                            m_lr[c][i][29:28] = 2'd0;
                            done = 1'b1;
                        end
                end else if (a >= 'h40 && a <= 'h4c && a % 4 == 0) m_lr[c][(a - 'h40) / 4] = req_wdata;
                else e_de = 1'b1;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            logic [3:0] ev;
            for (int c = 0; c < 4; c++) begin
                ev[c] = 1'b0;
                for (int i = 0; i < 4; i++) if (m_lr[c][i][29:28] == 2'd1) ev[c] = m_en[c];
            end
            chk(virq == ev, "R9 virq", {28'd0, virq}, {28'd0, ev});
            chk(rsp_valid == e_rv, "R13 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
            if (e_rv) chk(rsp_rdata == e_rd, cur_tag, rsp_rdata, e_rd);
            chk(hw_err == e_hw, "R8 hw_err", {31'd0, hw_err}, {31'd0, e_hw});
            chk(dec_err == e_de, "R11 dec_err", {31'd0, dec_err}, {31'd0, e_de});
        end
    end

    task automatic op(input bit wr, input int c, input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cpu = 2'(c); req_addr = 8'(a); req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int vid, input int src, input int prio, input int st, input bit hw);
        return {hw, 1'b0, 2'(st), 5'(prio), 3'd0, 1'b1, 6'd0, 3'(src), 10'(vid)};
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R13 watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // Reset state.
        cur_tag = "R1 reset ctrl"; op(0, 0, 'h00, 0);
        cur_tag = "R10 reset entry"; op(0, 0, 'h44, 0); op(0, 3, 'h4c, 0);
        // Full-word entry storage.
        cur_tag = "R10 entry rw";
        op(1, 0, 'h40, 32'hFFFF_FFFF); op(0, 0, 'h40, 0);
        op(1, 0, 'h40, 32'h0000_0000); op(0, 0, 'h40, 0);
        // Disabled or empty bank.
        cur_tag = "R2 disabled";
        op(1, 0, 'h40, mk(5, 1, 3, 1, 0)); op(0, 0, 'h04, 0); op(0, 0, 'h40, 0);
        cur_tag = "R1 enable"; op(1, 0, 'h00, 32'hFFFF_FFFF); op(0, 0, 'h00, 0);
        // Priority order and ties.
        cur_tag = "R5 order";
        op(1, 0, 'h44, mk(7, 2, 1, 1, 0)); op(1, 0, 'h48, mk(9, 3, 1, 1, 0));
        op(1, 0, 'h4c, mk(11, 0, 0, 1, 0));
        op(0, 0, 'h04, 0); op(0, 0, 'h04, 0); op(0, 0, 'h04, 0);
        cur_tag = "R3 last ack, virq drops same cycle"; op(0, 0, 'h04, 0);
        cur_tag = "R2 empty"; op(0, 0, 'h04, 0);
        cur_tag = "R4 state active";
        for (int i = 0; i < 4; i++) op(0, 0, 'h40 + 4 * i, 0);
        // Completion.
        cur_tag = "R6 eoi"; op(1, 0, 'h08, {19'd0, 3'd2, 10'd7}); op(0, 0, 'h44, 0);
        cur_tag = "R7 eoi miss"; op(1, 0, 'h08, {19'd0, 3'd1, 10'd7}); op(0, 0, 'h48, 0);
        cur_tag = "R6 eoi pending drops virq";
        op(1, 0, 'h44, mk(7, 2, 4, 1, 0)); op(1, 0, 'h08, {19'd0, 3'd2, 10'd7}); op(0, 0, 'h44, 0);
        // Hardware-linked entry.
        cur_tag = "R8 hw";
        op(1, 0, 'h40, mk(3, 0, 0, 1, 1)); op(0, 0, 'h04, 0); op(0, 0, 'h40, 0);
        // Undecoded.
        cur_tag = "R11 undecoded";
        op(0, 0, 'h10, 0); op(0, 0, 'h08, 0); op(1, 0, 'h04, 32'h1); op(0, 0, 'h42, 0);
        op(1, 0, 'h50, 32'h5); op(0, 0, 'h40, 0);
        // Banking.
        cur_tag = "R12 banking";
        op(1, 1, 'h00, 1); op(1, 1, 'h40, mk(1, 1, 2, 1, 0)); op(0, 2, 'h40, 0);
        op(0, 0, 'h04, 0); op(0, 1, 'h04, 0); op(0, 1, 'h40, 0);
        idle(); idle();
        // Random mix over all banks.
        cur_tag = "R3 random";
        for (int n = 0; n < 4000; n++) begin
            automatic int r = $urandom % 100;
            automatic int c = $urandom % 4;
            if (r < 30) op(1, c, 'h40 + 4 * ($urandom % 4),
                           mk($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 4, ($urandom % 12) == 0));
            else if (r < 60) op(0, c, 'h04, 0);
            else if (r < 82) op(1, c, 'h08, {19'd0, 3'($urandom % 2), 10'($urandom % 4)});
            else if (r < 88) op(1, c, 'h00, 32'($urandom % 4 != 0));
            else if (r < 95) op(0, c, 'h40 + 4 * ($urandom % 4), 0);
            else if (r < 98) op(0, c, 'h00, 0);
            else idle();
        end
        idle(); idle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule